// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner

The block reads a sixteen-key switch matrix wired as four row lines and four column lines. It pulls one row low at a time, lets the lines settle, and samples the columns through a two-stage synchronizer. A lone low column marks a candidate key. The block then holds that row for a debounce window and samples the columns again. If the pattern still matches, the block reports a 4-bit key number with a strobe that lasts one clock.

After it reports, the block pulls every row low together. It waits until all columns have read high, without a break, for one full debounce window before scanning restarts at the first row. A key held down for a long time therefore produces a single code. Contact bounce on release cannot create a second one. The debounce window is derived from the clock frequency and a time in microseconds. Both are parameters, so a bench can shrink the window to a few hundred clocks.

Top module: `keypad_scanner`

## Requirements
- R1: While scanning, `row_n` has exactly one bit low. Row i is active when `row_n[i]` is 0. Each row is held for SETTLE_CYCLES clocks, and the rows are visited in the order 0, 1, 2, 3, 0, and so on. At all other times `row_n` is either one-low or all zero.
- R2: A key at row r, column c closes when `row_n[r]` is low, and it pulls `col_in[c]` low. An undriven column reads high. A pressed key is detected and later reported.
- R3: The debounce window is (CLK_HZ / 1,000,000) * DEBOUNCE_US clocks. The report comes no earlier than one window after the press and no later than the window plus five row periods plus eight clocks. A closure that ends before the window is over produces no report.
- R4: At the end of the window, the column pattern on the same row is compared with the pattern that was captured. If they differ, scanning resumes with no report.
- R5: `key_code` equals row index * 4 + column index, giving a value from 0 to 15. The column index is the bit position of the low bit of `col_in`.
- R6: `key_valid` is high for exactly one clock per accepted key, and `key_code` is valid during that clock.
- R7: From the clock after `key_valid` onward, every row is driven low. Scanning restarts at row 0 only after all columns have read high without interruption for one debounce window. A key held down, or bouncing on release, therefore yields one code.
- R8: A sample in which more than one column is low is ignored. It produces no report.
- R9: While `rst_n` is low, `row_n` is 4'b1110 and `key_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| col_in | input | 4 | Column sense lines, idle high, low when a key on the active row is closed |
| row_n | output | 4 | Row drive lines, active low |
| key_code | output | 4 | Number of the accepted key |
| key_valid | output | 1 | One-clock strobe marking a new key_code |

## Verification
A wrong state in this block shows up first on `row_n`. A stuck or skipped state breaks the one-low rotation within one row period, and a failure to hold the row during debounce cuts the row dwell short. A state that leaves the release wait early shows as rows being driven again while a key is still down, and then as a second strobe one debounce window later. Errors in capture or comparison appear at the single `key_valid` clock, either as a wrong code or as a strobe for a pattern that should have been dropped. The bench therefore checks the row pattern on every clock, checks the strobe latency against its bounds, and counts strobes across long holds and across bounce sequences.

// File: rtl/kp_pkg.sv
`timescale 1ns/1ps
package kp_pkg;
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_DWELL = 2'd1,
    ST_EMIT  = 2'd2,
    ST_QUIET = 2'd3
  } kp_state_e;
endpackage

// File: rtl/kp_reset_sync.sv
`timescale 1ns/1ps
module kp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/kp_col_sync.sv
`timescale 1ns/1ps
module kp_col_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/kp_col_decode.sv
`timescale 1ns/1ps
module kp_col_decode #(
  parameter int COLS  = 4,
  parameter int COL_W = 2
) (
  input  logic [COLS-1:0]  cols,
  output logic             single,
  output logic [COL_W-1:0] idx
);
  logic [COL_W-1:0] part [COLS];

  for (genvar i = 0; i < COLS; i++) begin : g_part
    assign part[i] = cols[i] ? '0 : COL_W'(i);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < COLS; i++) idx = idx | part[i];
  end

  assign single = ($countones(~cols) == 1);
endmodule

// File: rtl/kp_timer.sv
`timescale 1ns/1ps
module kp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (en && (cnt_q != '1))   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/kp_scan_fsm.sv
`timescale 1ns/1ps
module kp_scan_fsm
  import kp_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int SETTLE = 8,
  parameter int DB     = 200,
  parameter int CNT_W  = 8,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   col_s,
  input  logic              col_single,
  input  logic [COL_W-1:0]  col_idx,
  input  logic [CNT_W-1:0]  tmr_cnt,
  output logic              tmr_clr,
  output logic              tmr_en,
  output logic [ROWS-1:0]   row_n,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] DB_LAST     = CNT_W'(DB - 1);
  localparam logic [ROW_W-1:0] ROW_LAST    = ROW_W'(ROWS - 1);

  kp_state_e          state_q, state_d;
  logic [ROW_W-1:0]   row_q, row_d, row_nxt;
  logic [COLS-1:0]    pat_q, pat_d;
  logic [CODE_W-1:0]  code_q, code_d;

  assign row_nxt = (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    pat_d   = pat_q;
    code_d  = code_q;
    tmr_clr = 1'b0;
    tmr_en  = 1'b1;
    unique case (state_q)
      ST_SCAN: begin
        if (tmr_cnt == SETTLE_LAST) begin
          tmr_clr = 1'b1;
          if (col_single) begin
            state_d = ST_DWELL;
            pat_d   = col_s;
            code_d  = CODE_W'(CODE_W'(row_q) * CODE_W'(COLS) + CODE_W'(col_idx));
          end else begin
            row_d = row_nxt;
          end
        end
      end
      ST_DWELL: begin
        if (tmr_cnt == DB_LAST) begin
          tmr_clr = 1'b1;
          if (col_s == pat_q) begin
            state_d = ST_EMIT;
          end else begin
            state_d = ST_SCAN;
            row_d   = row_nxt;
          end
        end
      end
      ST_EMIT: begin
        tmr_clr = 1'b1;
        tmr_en  = 1'b0;
        state_d = ST_QUIET;
      end
      ST_QUIET: begin
        if (col_s != '1) begin
          tmr_clr = 1'b1;
        end else if (tmr_cnt == DB_LAST) begin
          tmr_clr = 1'b1;
          state_d = ST_SCAN;
          row_d   = '0;
        end
      end
      default: begin
        tmr_clr = 1'b1;
        state_d = ST_SCAN;
        row_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SCAN;
      row_q   <= '0;
      pat_q   <= '1;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      pat_q   <= pat_d;
      code_q  <= code_d;
    end
  end

  always_comb begin
    if (state_q == ST_QUIET) row_n = '0;
    else                     row_n = ~(ROWS'(1) << row_q);
  end

  assign key_valid = (state_q == ST_EMIT);
  assign key_code  = code_q;
endmodule

// File: rtl/keypad_scanner.sv
`timescale 1ns/1ps
module keypad_scanner #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int DEBOUNCE_US   = 20_000,
  parameter int SETTLE_CYCLES = 8,
  parameter int ROWS          = 4,
  parameter int COLS          = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [COLS-1:0]                 col_in,
  output logic [ROWS-1:0]                 row_n,
  output logic [$clog2(ROWS*COLS)-1:0]    key_code,
  output logic                            key_valid
);
  localparam int DB_CYCLES = (CLK_HZ / 1_000_000) * DEBOUNCE_US;
  localparam int CNT_MAX   = (DB_CYCLES > SETTLE_CYCLES) ? DB_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int COL_W     = $clog2(COLS);
  localparam int CODE_W    = $clog2(ROWS * COLS);
  localparam int SYNC_LEN  = 2;

  logic              srst_n;
  logic [COLS-1:0]   col_s;
  logic              col_single;
  logic [COL_W-1:0]  col_idx;
  logic [CNT_W-1:0]  tmr_cnt;
  logic              tmr_clr;
  logic              tmr_en;

  kp_reset_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  kp_col_sync #(.WIDTH(COLS), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(col_in), .q(col_s)
  );

  kp_col_decode #(.COLS(COLS), .COL_W(COL_W)) u_dec (
    .cols(col_s), .single(col_single), .idx(col_idx)
  );

  kp_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(srst_n), .clr(tmr_clr), .en(tmr_en), .cnt(tmr_cnt)
  );

  kp_scan_fsm #(
    .ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE_CYCLES), .DB(DB_CYCLES),
    .CNT_W(CNT_W), .ROW_W(ROW_W), .COL_W(COL_W), .CODE_W(CODE_W)
  ) u_fsm (
    .clk(clk), .rst_n(srst_n),
    .col_s(col_s), .col_single(col_single), .col_idx(col_idx),
    .tmr_cnt(tmr_cnt), .tmr_clr(tmr_clr), .tmr_en(tmr_en),
    .row_n(row_n), .key_code(key_code), .key_valid(key_valid)
  );
endmodule

// File: rtl/kp_checker.sv
`timescale 1ns/1ps
module kp_checker #(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int DB_CYCLES = 200
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ROWS-1:0]              row_n,
  input logic [$clog2(ROWS*COLS)-1:0] key_code,
  input logic                         key_valid
);
  logic [ROWS-1:0] prev_row;
  int              hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_row <= '1;
      hold_cnt <= 0;
    end else begin
      prev_row <= row_n;
      if (row_n != prev_row)       hold_cnt <= 0;
      else if (hold_cnt < DB_CYCLES) hold_cnt <= hold_cnt + 1;
    end
  end

  // R1
  row_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_n != '0) |-> ($countones(~row_n) == 1));

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  // R7
  quiet_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (row_n == '0));

  // R5
  code_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (row_n == ~(ROWS'(1) << (key_code / COLS))));

  // R3
  dwell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (hold_cnt >= DB_CYCLES));
endmodule

bind keypad_scanner kp_checker #(
  .ROWS(ROWS), .COLS(COLS), .DB_CYCLES(DB_CYCLES)
) u_kp_chk (
  .clk(clk), .rst_n(rst_n), .row_n(row_n), .key_code(key_code), .key_valid(key_valid)
);

// File: tb/sim_keypad_scanner.sv
`timescale 1ns/1ps
module sim_keypad_scanner;
  localparam int DB     = 200;
  localparam int SETTLE = 8;

  logic       clk;
  logic       rst_n;
  logic [3:0] col_in;
  logic [3:0] row_n;
  logic [3:0] key_code;
  logic       key_valid;
  logic [15:0] keys;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int wide = 0;
  int last_code = -1;
  int last_pulse_cyc = 0;
  bit prev_v = 0;
  bit done = 0;

  keypad_scanner #(
    .CLK_HZ(200_000_000), .DEBOUNCE_US(1), .SETTLE_CYCLES(SETTLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .col_in(col_in),
    .row_n(row_n), .key_code(key_code), .key_valid(key_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    col_in = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (!row_n[r] && keys[r*4+c]) col_in[c] = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (key_valid) begin
      pulses++;
      last_code = int'(key_code);
      last_pulse_cyc = cyc;
      if (prev_v) wide++;
    end
    prev_v = key_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit one_low(input logic [3:0] r);
    return $countones(~r) == 1;
  endfunction

  function automatic int low_idx(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (!r[i]) return i;
    return -1;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b1;
    keys  = '0;
    #1 rst_n = 1'b0;
    wait_cyc(4);
    check(row_n == 4'b1110, "R9 row_n", int'(row_n), 14);
    check(key_valid == 1'b0, "R9 key_valid", int'(key_valid), 0);
    rst_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_scan();
    logic [3:0] prev;
    int run = 0, runs = 0, bad_pat = 0, bad_run = 0, bad_ord = 0;
    bit [3:0] seen = '0;
    prev = row_n;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!one_low(row_n)) bad_pat++;
      else seen[low_idx(row_n)] = 1'b1;
      if (row_n == prev) run++;
      else begin
        if (runs > 0 && run + 1 != SETTLE) bad_run++;
        if (low_idx(row_n) != (low_idx(prev) + 1) % 4) bad_ord++;
        runs++;
        run = 0;
      end
      prev = row_n;
    end
    check(bad_pat == 0, "R1 one-low pattern", bad_pat, 0);
    check(bad_run == 0, "R1 row dwell", bad_run, 0);
    check(bad_ord == 0, "R1 row order", bad_ord, 0);
    check(seen == 4'hF, "R1 rows visited", int'(seen), 15);
  endtask

  task automatic t_press(input int code);
    int t0, lat;
    bit got = 0;
    pulses = 0;
    wide = 0;
    @(negedge clk);
    keys[code] = 1'b1;
    t0 = cyc;
    for (int i = 0; i < DB + 120; i++) begin
      @(negedge clk);
      if (pulses > 0) begin got = 1; break; end
    end
    check(got, "R2 key reported", int'(got), 1);
    check(last_code == code, "R5 key_code", last_code, code);
    lat = last_pulse_cyc - t0;
    check(lat >= DB && lat <= DB + 5*SETTLE + 8, "R3 latency", lat, DB);
    @(negedge clk);
    check(key_valid == 1'b0, "R6 strobe dropped", int'(key_valid), 0);
    check(row_n == 4'b0000, "R7 rows all low", int'(row_n), 0);
    wait_cyc(DB / 2);
    check(pulses == 1 && wide == 0, "R6 one strobe", pulses, 1);
    keys[code] = 1'b0;
    wait_cyc(DB + 30);
    check(one_low(row_n), "R7 scan resumed", int'(row_n), 14);
  endtask

  task automatic t_hold();
    pulses = 0;
    keys[9] = 1'b1;
    wait_cyc(5 * DB);
    check(row_n == 4'b0000, "R7 rows low while held", int'(row_n), 0);
    keys[9] = 1'b0;
    wait_cyc(DB + 40);
    check(pulses == 1, "R7 one code per long hold", pulses, 1);
    check(last_code == 9, "R5 held key code", last_code, 9);
  endtask

  task automatic t_short();
    pulses = 0;
    keys[6] = 1'b1;
    wait_cyc(50);
    keys[6] = 1'b0;
    wait_cyc(3 * DB);
    check(pulses == 0, "R3 short closure ignored", pulses, 0);
    check(one_low(row_n), "R3 still scanning", int'(row_n), 14);
  endtask

  task automatic t_multi();
    pulses = 0;
    keys[4] = 1'b1;
    keys[5] = 1'b1;
    wait_cyc(3 * DB);
    check(pulses == 0, "R8 two columns ignored", pulses, 0);
    check(one_low(row_n), "R8 still scanning", int'(row_n), 13);
    keys[4] = 1'b0;
    keys[5] = 1'b0;
    wait_cyc(20);
  endtask

  task automatic t_change();
    pulses = 0;
    keys[2] = 1'b1;
    wait_cyc(100);
    keys[2] = 1'b0;
    keys[3] = 1'b1;
    wait_cyc(150);
    keys[3] = 1'b0;
    wait_cyc(3 * DB);
    check(pulses == 0, "R4 changed pattern dropped", pulses, 0);
  endtask

  task automatic t_bounce_release();
    bit got = 0;
    pulses = 0;
    keys[12] = 1'b1;
    for (int i = 0; i < DB + 120; i++) begin
      @(negedge clk);
      if (pulses > 0) begin got = 1; break; end
    end
    check(got && last_code == 12, "R5 code 12", last_code, 12);
    keys[12] = 1'b0;
    wait_cyc(50);
    keys[12] = 1'b1;
    wait_cyc(50);
    keys[12] = 1'b0;
    wait_cyc(30);
    keys[12] = 1'b1;
    wait_cyc(20);
    keys[12] = 1'b0;
    check(row_n == 4'b0000, "R7 release wait restarted", int'(row_n), 0);
    wait_cyc(3 * DB);
    check(pulses == 1, "R7 bounce gives one code", pulses, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_scan();
    t_press(0);
    t_press(5);
    t_press(10);
    t_press(15);
    t_press(7);
    t_hold();
    t_short();
    t_multi();
    t_change();
    t_bounce_release();
    t_press(14);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule